// File: doc/BRIEF.md
# Multi-Input Wake-Up Debouncer

This block watches a set of wake-up inputs sampled on a slow clock and decides when the core power domain should be woken. Each input can be switched on or off individually, and each has its own polarity. An input counts as active when its level matches its polarity bit. All enabled, active inputs are combined into one signal, and a single shared debouncer runs on that signal. The qualifying hold time is chosen by a 3-bit code that is common to all inputs.

When the combined signal has been active for the selected number of consecutive slow-clock samples, the block issues a one-cycle wake request. It also sets a sticky "a pin woke the core" flag, and it records which enabled inputs were active on that triggering edge. The flag and the per-input record hold until a status read strobe clears them. Configuration reaches the block as plain vectors; no register decoding happens here.

Top module: `wake_dbnc`

## Requirements
- R1: An input whose enable bit is 0 has no effect: it never starts the debouncer and never appears in the source record.
- R2: Input i is active when its level equals its type bit: type 1 means active high, type 0 means active low.
- R3: With hold code 0, a single slow-clock edge that samples the combined input active triggers. `wake_req` is high in the cycle after that edge.
- R4: Hold codes 1, 2, 3 and 4 require 3, 32, 512 and 4096 consecutive active samples. `wake_req` rises in the cycle after the edge that takes the last required sample, and one sample fewer never triggers.
- R5: Hold codes 5, 6 and 7 all require 32768 consecutive active samples.
- R6: The consecutive-sample count restarts from zero whenever the combined input is sampled inactive.
- R7: `wake_req` is high for exactly one cycle per trigger. No new trigger occurs until the combined input has been sampled inactive, even if the set of active inputs changes in the meantime.
- R8: `wake_any` sets on a trigger and stays set until a status read.
- R9: On a trigger, bit i of `wake_src` is set if input i is enabled and active on the triggering edge. Further triggers OR more bits in until a read.
- R10: A `status_rd` pulse clears `wake_any` and `wake_src` on the next edge. A trigger on that same edge wins, leaving only that trigger's flag and source bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow sampling clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_pin | input | N_IN | Raw wake-up input levels |
| pin_en | input | N_IN | Per-input enable |
| pin_type | input | N_IN | Per-input active level (1 high, 0 low) |
| hold_code | input | 3 | Shared debounce period code |
| status_rd | input | 1 | Status read strobe, clears flag and source record |
| wake_req | output | 1 | One-cycle core wake-up request |
| wake_any | output | 1 | Sticky pin wake-up flag |
| wake_src | output | N_IN | Sticky record of inputs active at trigger |

## Verification
The debouncer is driven with four kinds of pattern:
- Single-sample pulses under code 0, which show that code 0 is immediate and that polarity is honoured.
- Holds of exactly N-1 and N samples for every period code, which pin down each threshold to one cycle and show that codes 6 and 7 alias code 5.
- Broken bursts, which separate a counter that restarts from one that merely pauses.
- Hand-overs between overlapping inputs, multi-input snapshots and a read on the same edge as a trigger, which tell a correct one-shot, a correct accumulating record and correct read-versus-set priority from the plausible wrong variants.

// File: rtl/wkdb_pkg.sv
package wkdb_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_HOLD = 32768;
  localparam int RUN_W    = $clog2(MAX_HOLD + 1);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [RUN_W-1:0]  run_t;

  // Consecutive active samples needed for a hold code.
  function automatic run_t hold_len(code_t c);
    case (c)
      3'd0:    return run_t'(1);
      3'd1:    return run_t'(3);
      3'd2:    return run_t'(32);
      3'd3:    return run_t'(512);
      3'd4:    return run_t'(4096);
      default: return run_t'(MAX_HOLD);
    endcase
  endfunction
endpackage

// File: rtl/wkdb_rst_sync.sv
module wkdb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/wkdb_qualify.sv
module wkdb_qualify #(
  parameter int N_IN = 14
) (
  input  logic [N_IN-1:0] pin,
  input  logic [N_IN-1:0] en,
  input  logic [N_IN-1:0] ptype,
  output logic [N_IN-1:0] active,
  output logic            any_active
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lane
    // R2: active when level equals type; R1: gated by enable
    assign active[i] = en[i] & ~(pin[i] ^ ptype[i]);
  end

  assign any_active = |active;
endmodule

// File: rtl/wkdb_counter.sv
module wkdb_counter
  import wkdb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  any_active,
  input  code_t code,
  output logic  hit
);
  run_t run_q, run_d;
  logic fired_q, fired_d;
  run_t need;
  run_t run_inc;

  always_comb begin
    need    = hold_len(code);
    run_inc = run_q + run_t'(1);
    hit     = any_active & ~fired_q & (run_inc >= need);
    if (!any_active) begin
      run_d   = '0;          // R6 restart
      fired_d = 1'b0;        // R7 re-arm
    end else begin
      run_d   = (run_q < run_t'(MAX_HOLD)) ? run_inc : run_q;
      fired_d = fired_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      fired_q <= fired_d;
    end
  end

  assert_run_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= run_t'(MAX_HOLD));
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_active |=> (run_q == '0));
  assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/wkdb_status.sv
module wkdb_status #(
  parameter int N_IN = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [N_IN-1:0] active,
  input  logic            rd,
  output logic            pulse_q,
  output logic            flag_q,
  output logic [N_IN-1:0] snap_q
);
  logic            pulse_d, flag_d;
  logic [N_IN-1:0] snap_d;

  always_comb begin
    pulse_d = hit;
    flag_d  = (rd ? 1'b0 : flag_q) | hit;                    // R8, R10
    snap_d  = (rd ? '0 : snap_q) | (hit ? active : '0);      // R9, R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      snap_q  <= '0;
    end else begin
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
      snap_q  <= snap_d;
    end
  end

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd) |=> flag_q);
  assert_src_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|snap_q) |-> flag_q);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (!flag_q && (snap_q == '0)));
endmodule

// File: rtl/wake_dbnc.sv
module wake_dbnc
  import wkdb_pkg::*;
#(
  parameter int N_IN = 14
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [N_IN-1:0] wake_pin,
  input  logic [N_IN-1:0] pin_en,
  input  logic [N_IN-1:0] pin_type,
  input  logic [2:0]      hold_code,
  input  logic            status_rd,
  output logic            wake_req,
  output logic            wake_any,
  output logic [N_IN-1:0] wake_src
);
  logic            rst_n;
  logic [N_IN-1:0] active;
  logic            any_active;
  logic            hit;

  wkdb_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  wkdb_qualify #(.N_IN(N_IN)) u_qual (
    .pin        (wake_pin),
    .en         (pin_en),
    .ptype      (pin_type),
    .active     (active),
    .any_active (any_active)
  );

  wkdb_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_active (any_active),
    .code       (code_t'(hold_code)),
    .hit        (hit)
  );

  wkdb_status #(.N_IN(N_IN)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .active  (active),
    .rd      (status_rd),
    .pulse_q (wake_req),
    .flag_q  (wake_any),
    .snap_q  (wake_src)
  );

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0) |=> !wake_req);
endmodule

// File: tb/wake_dbnc_test.sv
module wake_dbnc_test;
  localparam int N = 14;

  logic         clk = 1'b0;
  logic         arst_n;
  logic [N-1:0] pins, en, typ;
  logic [2:0]   code;
  logic         rd;
  logic         wake_req, wake_any;
  logic [N-1:0] wake_src;

  int    errors = 0;
  int    checks = 0;
  int    pulses = 0;
  bit    done   = 0;
  string phase  = "R8";

  always #5 clk = ~clk;

  wake_dbnc #(.N_IN(N)) uut (
    .clk(clk), .arst_n(arst_n), .wake_pin(pins), .pin_en(en),
    .pin_type(typ), .hold_code(code), .status_rd(rd),
    .wake_req(wake_req), .wake_any(wake_any), .wake_src(wake_src)
  );

  // behavioural reference model
  int           m_run;
  bit           m_fired, m_pulse, m_flag, m_rs1, m_rs2;
  logic [N-1:0] m_snap;

  function automatic int need_of(logic [2:0] c);
    if (c == 0) return 1;
    if (c == 1) return 3;
    if (c == 2) return 32;
    if (c == 3) return 512;
    if (c == 4) return 4096;
    return 32768;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_run = 0; m_fired = 0;
      m_pulse = 0; m_flag = 0; m_snap = '0;
    end else begin
      if (m_rs2) begin
        logic [N-1:0] act;
        bit any, h;
        act = '0;
        for (int i = 0; i < N; i++)
          if (en[i] && pins[i] == typ[i]) act[i] = 1'b1;
        any = (act != '0);
        h = any && !m_fired && (m_run + 1 >= need_of(code));
        m_pulse = h;
        m_flag  = (rd ? 1'b0 : m_flag) | h;
        m_snap  = (rd ? '0 : m_snap) | (h ? act : '0);
        if (!any) begin m_run = 0; m_fired = 0; end
        else begin
          if (m_run < 32768) m_run++;
          if (h) m_fired = 1;
        end
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(wake_req == m_pulse, {phase, " wake_req"}, wake_req, m_pulse);
      chk(wake_any == m_flag,  {phase, " wake_any"}, wake_any, m_flag);
      chk(wake_src == m_snap,  {phase, " wake_src"}, wake_src, m_snap);
      if (wake_req) pulses++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulses(int n, string tag);
    chk(pulses == n, {tag, " pulse count"}, pulses, n);
    pulses = 0;
  endtask

  task automatic do_read();
    rd = 1; step(1); rd = 0;
    chk(!wake_any && wake_src == '0, "R10 read clear", {wake_any, wake_src}, 0);
  endtask

  task automatic hold(int bitn, int n, string tag, int exp);
    pins[bitn] = 1; step(n); pins[bitn] = 0; step(2);
    expect_pulses(exp, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    arst_n = 0; pins = '0; en = '0; typ = '1; code = 3'd0; rd = 0;
    step(3);
    chk(!wake_req && !wake_any && wake_src == '0, "R8 reset state",
        {wake_req, wake_any, wake_src}, 0);
    arst_n = 1; step(4);

    // R3: code 0, one active sample
    phase = "R3"; en = 14'h0001;
    hold(0, 1, "R3 immediate", 1);
    chk(wake_any == 1'b1 && wake_src == 14'h0001, "R9 single src", wake_src, 14'h0001);
    do_read();

    // R1: disabled input
    phase = "R1"; en = 14'h0001;
    pins[3] = 1; step(6); pins[3] = 0; step(2);
    expect_pulses(0, "R1 disabled");
    chk(!wake_any, "R1 no flag", wake_any, 0);

    // R2: active-low input
    phase = "R2"; typ[5] = 0; pins[5] = 1; en = 14'h0020; step(3);
    expect_pulses(0, "R2 idle high");
    pins[5] = 0; step(4); pins[5] = 1; step(2);
    expect_pulses(1, "R2 active low");
    chk(wake_src == 14'h0020, "R2 src", wake_src, 14'h0020);
    do_read(); en = '0; typ = '1; pins = '0; step(2);

    // R6: broken bursts under code 1
    phase = "R6"; code = 3'd1; en = 14'h0004;
    pins[2] = 1; step(2); pins[2] = 0; step(1); pins[2] = 1; step(2); pins[2] = 0; step(2);
    expect_pulses(0, "R6 restart");
    hold(2, 3, "R4 code1 exact", 1);
    do_read();

    // R4: thresholds
    phase = "R4";
    code = 3'd2; hold(2, 31, "R4 code2 short", 0); hold(2, 32, "R4 code2 exact", 1);
    code = 3'd3; hold(2, 511, "R4 code3 short", 0); hold(2, 512, "R4 code3 exact", 1);
    code = 3'd4; hold(2, 4095, "R4 code4 short", 0); hold(2, 4096, "R4 code4 exact", 1);
    do_read();

    // R5: long codes
    phase = "R5";
    code = 3'd5; hold(2, 32767, "R5 code5 short", 0); hold(2, 32768, "R5 code5 exact", 1);
    code = 3'd6; hold(2, 32768, "R5 code6", 1);
    code = 3'd7; hold(2, 32767, "R5 code7 short", 0);
    do_read();

    // R7: no retrigger across hand-over, rearm after drop
    phase = "R7"; code = 3'd0; en = 14'h0003;
    pins[0] = 1; step(3); pins[1] = 1; step(1); pins[0] = 0; step(3); pins[1] = 0; step(2);
    expect_pulses(1, "R7 handover");
    hold(1, 5, "R7 rearm", 1);

    // R8: sticky flag
    phase = "R8"; step(20);
    chk(wake_any == 1'b1, "R8 sticky", wake_any, 1);
    do_read();

    // R9: multi-input snapshot and accumulation
    phase = "R9"; code = 3'd1; en = 14'h0203;
    pins[0] = 1; pins[9] = 1; pins[12] = 1; step(3); pins = '0; step(2);
    expect_pulses(1, "R9 multi");
    chk(wake_src == 14'h0201, "R9 snapshot", wake_src, 14'h0201);
    hold(1, 3, "R9 second", 1);
    chk(wake_src == 14'h0203, "R9 accumulate", wake_src, 14'h0203);

    // R10: read on the same edge as a trigger
    phase = "R10"; code = 3'd0;
    rd = 1; pins[0] = 1; step(1); rd = 0; pins[0] = 0; step(1);
    chk(wake_any == 1'b1 && wake_src == 14'h0001, "R10 set wins", wake_src, 14'h0001);
    expect_pulses(1, "R10 pulse");
    do_read();
    step(3);
    finish_run();
  end
endmodule